// File: doc/BRIEF.md
# Host-to-Coprocessor Command Mailbox

This block sits between a host CPU and a secure coprocessor. The host sees a 32-bit word-addressed register bus. On that bus it loads sixteen argument registers and then writes a command word. The command write takes the command and a snapshot of all sixteen arguments and places them together as one entry in a four-deep first-in, first-out queue.

The coprocessor drains that queue through its own port. It sees the oldest entry and removes it with a pop strobe. When it has finished a command, it presents a return word and sixteen result words and pulses a done strobe. That pulse loads the results into host-readable registers and raises a completion event.

Three events are recorded in an interrupt status register, which is cleared by writing ones:
- command completion;
- a command write refused because the queue was full;
- the queue becoming full.

A mask register, in which a set bit disables a source, gates these events onto a single host interrupt line.

Top module: `cmd_mailbox`

## Requirements
- R1: Argument register i (i = 0..15) sits at byte offset 4*i. A write stores the word, and a read returns the last value written. A command submission leaves the argument registers unchanged.
- R2: A write to offset 0x40 while occupancy is below 4 pushes the command word and the current sixteen arguments into the queue. Occupancy then rises by one. The status register at 0xC4 reports occupancy in bits [2:0] and the level of `cp_ready` in bit 8.
- R3: Whenever the queue is non-empty, `cp_cmd_valid` is high and `cp_cmd`/`cp_args` show the oldest entry, with argument i at bits [32*i+31:32*i]. A `cp_pop` pulse removes that entry, so entries leave in submission order.
- R4: A push that brings occupancy to 4 sets interrupt status bit 18 (queue full).
- R5: A command write while occupancy is 4 is dropped. Occupancy and queued entries stay unchanged, and interrupt status bit 17 (refused access) is set.
- R6: A `cp_done` pulse loads `cp_ret` into the return register at 0x80 and result word i into the register at 0x84 + 4*i. It also sets interrupt status bit 0 (complete).
- R7: The interrupt status register at 0xC8 clears every bit that is 1 in the written word and leaves the other bits unchanged. A set event in the same cycle wins over the clear.
- R8: The mask register at 0xCC covers bits 0, 17 and 18, and resets to 0x00060001 (all sources disabled). `irq` is high exactly when some status bit is set and its mask bit is 0.
- R9: After reset, occupancy is 0, interrupt status is 0, `cp_cmd_valid` is low and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Host write strobe |
| bus_addr | input | 8 | Host byte address |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data for `bus_addr` |
| irq | output | 1 | Host interrupt |
| cp_ready | input | 1 | Coprocessor ready level, reported at 0xC4 bit 8 |
| cp_cmd_valid | output | 1 | Queue holds at least one entry |
| cp_cmd | output | 32 | Command word of the oldest entry |
| cp_args | output | 512 | Sixteen arguments of the oldest entry |
| cp_pop | input | 1 | Remove the oldest entry |
| cp_done | input | 1 | Completion strobe |
| cp_ret | input | 32 | Return word loaded on `cp_done` |
| cp_results | input | 512 | Sixteen result words loaded on `cp_done` |

## Verification
Every register-changing stimulus (a bus write, `cp_pop`, `cp_done`) takes effect at the next rising edge. Because `bus_rdata` and `irq` decode the registers combinationally, each result is due in the very cycle after the stimulus edge. The bench therefore drives stimulus on falling edges and removes it on the following falling edge. It reads back and compares at a falling edge, after the updating edge and before the next one. The queue outputs follow the same rule, so each pop is checked by sampling `cp_cmd` one falling edge after the pop was driven.

// File: rtl/cmd_mailbox.sv
module cmd_mailbox #(
  parameter int DATA_W = 32,
  parameter int NARGS  = 16,
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_wr,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [DATA_W-1:0]       bus_wdata,
  output logic [DATA_W-1:0]       bus_rdata,
  output logic                    irq,
  input  logic                    cp_ready,
  output logic                    cp_cmd_valid,
  output logic [DATA_W-1:0]       cp_cmd,
  output logic [NARGS*DATA_W-1:0] cp_args,
  input  logic                    cp_pop,
  input  logic                    cp_done,
  input  logic [DATA_W-1:0]       cp_ret,
  input  logic [NARGS*DATA_W-1:0] cp_results
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int IDX_W = (NARGS > 1) ? $clog2(NARGS) : 1;
  localparam logic [ADDR_W-1:0] CMD_A  = ADDR_W'(NARGS * 4);
  localparam logic [ADDR_W-1:0] RET_A  = ADDR_W'(NARGS * 8);
  localparam logic [ADDR_W-1:0] RES_A  = ADDR_W'(NARGS * 8 + 4);
  localparam logic [ADDR_W-1:0] FIFO_A = ADDR_W'(NARGS * 12 + 4);
  localparam logic [ADDR_W-1:0] INT_A  = ADDR_W'(NARGS * 12 + 8);
  localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(NARGS * 12 + 12);
  localparam int B_DONE = 0;
  localparam int B_FACC = 17;
  localparam int B_FULL = 18;
  localparam logic [DATA_W-1:0] SRC_BITS =
    (DATA_W'(1) << B_DONE) | (DATA_W'(1) << B_FACC) | (DATA_W'(1) << B_FULL);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [DATA_W-1:0]       arg_q [NARGS];
  logic [DATA_W-1:0]       res_q [NARGS];
  logic [DATA_W-1:0]       ret_q;
  logic [DATA_W-1:0]       q_cmd [DEPTH];
  logic [NARGS*DATA_W-1:0] q_arg [DEPTH];
  logic [NARGS*DATA_W-1:0] args_flat;
  logic [PTR_W-1:0]        wptr, rptr;
  logic [CNT_W-1:0]        count;
  logic [DATA_W-1:0]       stat_q, mask_q, set_v, clr_v;

  logic aligned, wr_arg, wr_cmd, wr_int, wr_mask, push, drop, pop;
  logic [ADDR_W-1:0] res_off;

  assign aligned = (bus_addr[1:0] == 2'b00);
  assign wr_arg  = bus_wr && aligned && (bus_addr < CMD_A);
  assign wr_cmd  = bus_wr && (bus_addr == CMD_A);
  assign wr_int  = bus_wr && (bus_addr == INT_A);
  assign wr_mask = bus_wr && (bus_addr == MASK_A);
  assign push    = wr_cmd && (count != FULL_CNT);
  assign drop    = wr_cmd && (count == FULL_CNT);
  assign pop     = cp_pop && (count != '0);
  assign res_off = bus_addr - RES_A;

  for (genvar g = 0; g < NARGS; g++) begin : g_pack
    assign args_flat[g*DATA_W +: DATA_W] = arg_q[g];
  end

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NARGS; i++) arg_q[i] <= '0;
    end else if (wr_arg) begin
      arg_q[bus_addr[IDX_W+1:2]] <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        q_cmd[i] <= '0;
        q_arg[i] <= '0;
      end
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) begin
        q_cmd[wptr] <= bus_wdata;
        q_arg[wptr] <= args_flat;
        wptr        <= nxt(wptr);
      end
      if (pop) rptr <= nxt(rptr);
      case ({push, pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  assign cp_cmd_valid = (count != '0);
  assign cp_cmd       = q_cmd[rptr];
  assign cp_args      = q_arg[rptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ret_q <= '0;
      for (int i = 0; i < NARGS; i++) res_q[i] <= '0;
    end else if (cp_done) begin
      ret_q <= cp_ret;
      for (int i = 0; i < NARGS; i++) res_q[i] <= cp_results[i*DATA_W +: DATA_W];
    end
  end

  always_comb begin
    set_v         = '0;
    set_v[B_DONE] = cp_done;
    set_v[B_FACC] = drop;
    set_v[B_FULL] = push && !pop && (count == FULL_CNT - CNT_W'(1));
    clr_v         = wr_int ? bus_wdata : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= SRC_BITS;
    end else begin
      stat_q <= ((stat_q & ~clr_v) | set_v) & SRC_BITS;
      if (wr_mask) mask_q <= bus_wdata & SRC_BITS;
    end
  end

  assign irq = |(stat_q & ~mask_q);

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      if (bus_addr < CMD_A)
        bus_rdata = arg_q[bus_addr[IDX_W+1:2]];
      else if (bus_addr == RET_A)
        bus_rdata = ret_q;
      else if (bus_addr >= RES_A && bus_addr < FIFO_A)
        bus_rdata = res_q[res_off[IDX_W+1:2]];
      else if (bus_addr == FIFO_A) begin
        bus_rdata[CNT_W-1:0] = count;
        bus_rdata[8]         = cp_ready;
      end
      else if (bus_addr == INT_A)
        bus_rdata = stat_q;
      else if (bus_addr == MASK_A)
        bus_rdata = mask_q;
    end
  end

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);
  assert_pop_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_pop && count != '0 && !wr_cmd) |=> count == $past(count) - CNT_W'(1));
  assert_full_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && !cp_pop && count == FULL_CNT - CNT_W'(1)) |=> stat_q[B_FULL]);
  assert_drop_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && !cp_pop && count == FULL_CNT) |=> (count == FULL_CNT) && stat_q[B_FACC]);
  assert_done_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cp_done |=> stat_q[B_DONE] && ret_q == $past(cp_ret));
  assert_w1c_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_int && bus_wdata[B_DONE] && !cp_done) |=> !stat_q[B_DONE]);
endmodule

// File: tb/cmd_mailbox_tb.sv
module cmd_mailbox_tb_top;
  logic         clk = 0;
  logic         rst_n = 0;
  logic         bus_wr = 0;
  logic [7:0]   bus_addr = 0;
  logic [31:0]  bus_wdata = 0;
  logic [31:0]  bus_rdata;
  logic         irq;
  logic         cp_ready = 0;
  logic         cp_cmd_valid;
  logic [31:0]  cp_cmd;
  logic [511:0] cp_args;
  logic         cp_pop = 0;
  logic         cp_done = 0;
  logic [31:0]  cp_ret = 0;
  logic [511:0] cp_results = 0;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cmd_mailbox dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .cp_ready(cp_ready), .cp_cmd_valid(cp_cmd_valid), .cp_cmd(cp_cmd),
    .cp_args(cp_args), .cp_pop(cp_pop), .cp_done(cp_done), .cp_ret(cp_ret),
    .cp_results(cp_results)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic t_reset;
    rd_chk("R9 occupancy", 8'hC4, 32'h0);
    rd_chk("R9 status", 8'hC8, 32'h0);
    rd_chk("R8 mask reset", 8'hCC, 32'h0006_0001);
    chk("R9 valid", {31'b0, cp_cmd_valid}, 32'h0);
    chk("R9 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_args;
    for (int i = 0; i < 16; i++) wr(8'(4*i), 32'hA000_0000 + 32'(i));
    @(negedge clk);
    for (int i = 0; i < 16; i++) rd_chk("R1 arg readback", 8'(4*i), 32'hA000_0000 + 32'(i));
  endtask

  task automatic submit(input int k);
    wr(8'h00, 32'h100 + 32'(k));
    wr(8'h3C, 32'h200 + 32'(k));
    wr(8'h40, 32'hC0DE_0000 + 32'(k));
  endtask

  task automatic t_queue;
    for (int k = 0; k < 3; k++) submit(k);
    rd_chk("R2 occupancy 3", 8'hC4, 32'h3);
    chk("R3 valid", {31'b0, cp_cmd_valid}, 32'h1);
    rd_chk("R4 not full yet", 8'hC8, 32'h0);
    rd_chk("R1 arg kept after submit", 8'h3C, 32'h202);
    submit(3);
    rd_chk("R4 occupancy 4", 8'hC4, 32'h4);
    rd_chk("R4 full bit", 8'hC8, 32'h0004_0000);
    submit(4);
    rd_chk("R5 occupancy unchanged", 8'hC4, 32'h4);
    rd_chk("R5 refused bit", 8'hC8, 32'h0006_0000);
    cp_ready = 1;
    @(negedge clk);
    rd_chk("R2 ready flag", 8'hC4, 32'h104);
    for (int k = 0; k < 4; k++) begin
      chk("R3 cmd order", cp_cmd, 32'hC0DE_0000 + 32'(k));
      chk("R3 arg0", cp_args[31:0], 32'h100 + 32'(k));
      chk("R3 arg15", cp_args[511:480], 32'h200 + 32'(k));
      cp_pop = 1;
      @(negedge clk);
      cp_pop = 0;
    end
    chk("R3 empty after drain", {31'b0, cp_cmd_valid}, 32'h0);
    rd_chk("R5 dropped entry absent", 8'hC4, 32'h100);
  endtask

  task automatic t_done;
    @(negedge clk);
    cp_ret = 32'h5A5A_0001;
    for (int i = 0; i < 16; i++) cp_results[i*32 +: 32] = 32'hBEEF_0000 + 32'(i);
    cp_done = 1;
    @(negedge clk);
    cp_done = 0;
    cp_ret = 0;
    cp_results = 0;
    rd_chk("R6 return", 8'h80, 32'h5A5A_0001);
    for (int i = 0; i < 16; i++) rd_chk("R6 result", 8'(8'h84 + 4*i), 32'hBEEF_0000 + 32'(i));
    rd_chk("R6 complete bit", 8'hC8, 32'h0006_0001);
    chk("R8 masked irq", {31'b0, irq}, 32'h0);
    wr(8'hCC, 32'h0006_0000);
    chk("R8 irq enabled", {31'b0, irq}, 32'h1);
    wr(8'hC8, 32'h0000_0001);
    rd_chk("R7 partial clear", 8'hC8, 32'h0006_0000);
    chk("R8 irq off with masked rest", {31'b0, irq}, 32'h0);
    wr(8'hCC, 32'h0);
    chk("R8 irq from full bits", {31'b0, irq}, 32'h1);
    wr(8'hC8, 32'h0006_0000);
    rd_chk("R7 all clear", 8'hC8, 32'h0);
    chk("R8 irq low", {31'b0, irq}, 32'h0);
    @(negedge clk);
    bus_wr = 1; bus_addr = 8'hC8; bus_wdata = 32'h1; cp_done = 1;
    @(negedge clk);
    bus_wr = 0; cp_done = 0;
    rd_chk("R7 set wins", 8'hC8, 32'h1);
  endtask

  initial begin
    #500000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_args();
    t_queue();
    t_done();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule